// File: doc/BRIEF.md
# Reference-Clock Frequency Offset Monitor

This block watches three clock inputs and compares the rate of each against a reference clock that also clocks the block. Every monitored input passes through a two-stage synchronizer into the reference domain. Its rising edges are then counted over a gate window. The window is a programmable number of reference cycles. When a window closes, each count is compared with a programmed expected count. If the absolute difference is greater than the limit selected for the current threshold class, that input's offset alarm is raised.

Two limit values are held side by side. The tight limit serves the Stratum 3/3E class and the loose limit serves the SONET minimum-clock class. One select input chooses which limit applies. The mapping assumes that both the reference and the monitored clocks are integer multiples of a common 19.44 MHz base. Software therefore sets each expected count to the window length scaled by the known frequency ratio.

Alarms are re-evaluated at every window end. A failing window sets an alarm at once. An alarm that is set only clears after two passing windows in a row, which gives hysteresis.

Top module: `fofs_monitor`

## Requirements
- R1: While reset is low and in the first cycle after it is released, every alarm bit and `win_end` are 0.
- R2: `win_end` is a one-cycle pulse that occurs once every `gate_len` reference cycles. A `gate_len` of 0 behaves as 1, so `win_end` stays high in every cycle.
- R3: Each rising edge of a monitored input is counted in the window during which it leaves the two-flop synchronizer, which is two reference cycles after it is sampled. An input whose count at window end lies within the limit of its expected count leaves its alarm clear.
- R4: At a window end, an input whose count differs from its expected count by more than the selected limit has its alarm set in the same cycle that `win_end` rises. A difference equal to the limit passes.
- R5: `lim_sel` = 0 selects `lim_tight` (the Stratum 3/3E class), and `lim_sel` = 1 selects `lim_loose` (the SONET minimum-clock class).
- R6: A window in which a monitored input shows no rising edge fails, even when its expected count is 0.
- R7: An alarm that is set stays set through one passing window and clears at the end of the second consecutive passing window. Alarm bits change only at window ends.
- R8: Alarm bit i depends only on input i and its expected count, which is field i of `expect_cnt` (bits i*CW to i*CW+CW-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, which also clocks the whole block |
| rst_n | input | 1 | Asynchronous reset, active low |
| mon_in | input | NMON | Monitored clock inputs (asynchronous) |
| gate_len | input | GW | Window length in reference cycles |
| expect_cnt | input | NMON*CW | Expected edge count per window, field i for input i |
| lim_sel | input | 1 | Threshold class select: 0 = tight, 1 = loose |
| lim_tight | input | CW | Allowed count difference for the tight class |
| lim_loose | input | CW | Allowed count difference for the loose class |
| alarm | output | NMON | Per-input frequency offset alarm |
| win_end | output | 1 | Pulses high when a window has just been evaluated |

## Verification
The bench builds the block with NMON=3, CW=12 and GW=10. It runs a 64-cycle window with monitored inputs whose periods are 4 and 8 reference cycles. Because 64 is a multiple of both periods, every settled window holds an exact count of 16 or 8 whatever the phase, so the limit boundaries (a difference equal to the limit and one above it) can be hit exactly. The short window brings both the two-window hysteresis and a later reset with `gate_len` = 0 (a window every cycle) within a few thousand cycles.

// File: rtl/fofs_monitor.sv
module fofs_monitor #(
  parameter int NMON = 3,
  parameter int CW   = 12,
  parameter int GW   = 10
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [NMON-1:0]   mon_in,
  input  logic [GW-1:0]     gate_len,
  input  logic [NMON*CW-1:0] expect_cnt,
  input  logic              lim_sel,
  input  logic [CW-1:0]     lim_tight,
  input  logic [CW-1:0]     lim_loose,
  output logic [NMON-1:0]   alarm,
  output logic              win_end
);

  logic [NMON-1:0] s1, s2, s3, rise;
  logic [GW-1:0]   wcnt;
  logic            last;
  logic [CW-1:0]   lim;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= '0;
      s2      <= '0;
      s3      <= '0;
      wcnt    <= '0;
      win_end <= 1'b0;
    end else begin
      s1      <= mon_in;
      s2      <= s1;
      s3      <= s2;
      wcnt    <= last ? '0 : wcnt + GW'(1);
      win_end <= last;
    end
  end

  assign rise = s2 & ~s3;
  assign last = ({1'b0, wcnt} + (GW+1)'(1)) >= {1'b0, gate_len};
  assign lim  = lim_sel ? lim_loose : lim_tight;

  for (genvar i = 0; i < NMON; i++) begin : g_ch
    logic [CW-1:0] cnt;
    logic [CW:0]   meas, expv, diff;
    logic          fail, alm, one_pass;

    assign expv = {1'b0, expect_cnt[i*CW +: CW]};
    assign meas = {1'b0, cnt} + {{CW{1'b0}}, rise[i]};
    assign diff = (meas > expv) ? meas - expv : expv - meas;
    assign fail = (meas == '0) || (diff > {1'b0, lim});

    always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
        cnt      <= '0;
        alm      <= 1'b0;
        one_pass <= 1'b0;
      end else if (last) begin
        cnt <= '0;
        if (fail) begin
          alm      <= 1'b1;
          one_pass <= 1'b0;
        end else if (alm && one_pass) begin
          alm      <= 1'b0;
          one_pass <= 1'b0;
        end else begin
          one_pass <= alm;
        end
      end else if (rise[i] && cnt != '1) begin
        cnt <= cnt + CW'(1);
      end
    end

    assign alarm[i] = alm;
  end

endmodule

// File: rtl/fofs_monitor_chk.sv
module fofs_monitor_chk #(
  parameter int NMON = 3,
  parameter int GW   = 10
) (
  input logic            clk_ref,
  input logic            rst_n,
  input logic [NMON-1:0] alarm,
  input logic            win_end,
  input logic [GW-1:0]   gate_len
);

  p_reset_quiet_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (rst_n && !$past(rst_n)) |-> (alarm == '0 && !win_end));

  p_single_pulse_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (win_end && gate_len > GW'(1)) |=> !win_end);

  p_alarm_hold_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !win_end |-> $stable(alarm));

  for (genvar i = 0; i < NMON; i++) begin : g_bit
    logic [1:0] hi_ends;
    always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)                       hi_ends <= '0;
      else if (!alarm[i])               hi_ends <= '0;
      else if (win_end && hi_ends != 2'd3) hi_ends <= hi_ends + 2'd1;
    end

    p_set_at_end_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(alarm[i]) |-> win_end);

    p_two_pass_clear_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $fell(alarm[i]) |-> (win_end && hi_ends >= 2'd2));
  end

endmodule

bind fofs_monitor fofs_monitor_chk #(.NMON(NMON), .GW(GW)) u_chk (
  .clk_ref (clk_ref),
  .rst_n   (rst_n),
  .alarm   (alarm),
  .win_end (win_end),
  .gate_len(gate_len)
);

// File: tb/fofs_monitor_bench.sv
`timescale 1ns/1ps
module fofs_monitor_bench;
  localparam int NMON = 3;
  localparam int CW   = 12;
  localparam int GW   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NMON-1:0] mon_in = '0;
  logic [GW-1:0] gate_len = GW'(64);
  logic [CW-1:0] ex [NMON];
  logic lim_sel = 1'b0;
  logic [CW-1:0] lim_tight = CW'(1);
  logic [CW-1:0] lim_loose = CW'(4);
  logic [NMON*CW-1:0] expect_cnt;
  logic [NMON-1:0] alarm;
  logic win_end;

  assign expect_cnt = {ex[2], ex[1], ex[0]};

  fofs_monitor #(.NMON(NMON), .CW(CW), .GW(GW)) u_fofs_monitor (
    .clk_ref(clk), .rst_n(rst_n), .mon_in(mon_in), .gate_len(gate_len),
    .expect_cnt(expect_cnt), .lim_sel(lim_sel), .lim_tight(lim_tight),
    .lim_loose(lim_loose), .alarm(alarm), .win_end(win_end));

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;

  // monitored clock generators: half period in reference cycles, 0 holds
  int hp [NMON] = '{2, 2, 4};
  int tc [NMON] = '{0, 0, 0};
  always @(negedge clk) begin
    for (int i = 0; i < NMON; i++) begin
      if (hp[i] != 0) begin
        tc[i] = tc[i] + 1;
        if (tc[i] >= hp[i]) begin
          tc[i] = 0;
          mon_in[i] <= ~mon_in[i];
        end
      end
    end
  end

  // behavioural reference model
  int  wpos;
  int  cnt [NMON];
  bit  pend [NMON][$];
  bit  prev [NMON];
  bit  m_alarm [NMON];
  bit  m_pass [NMON];
  bit  m_win;

  always @(posedge clk) begin
    if (!rst_n) begin
      wpos = 0; m_win = 0;
      for (int i = 0; i < NMON; i++) begin
        cnt[i] = 0; m_alarm[i] = 0; m_pass[i] = 0; prev[i] = 0;
        pend[i] = '{0, 0};
      end
    end else begin
      bit lst;
      lst = (wpos + 1 >= int'(gate_len));
      for (int i = 0; i < NMON; i++) begin
        bit v, inc;
        int meas, d, lim;
        v = pend[i].pop_front();
        inc = v && !prev[i];
        prev[i] = v;
        pend[i].push_back(mon_in[i]);
        if (lst) begin
          meas = cnt[i] + int'(inc);
          d = meas - int'(ex[i]);
          if (d < 0) d = -d;
          lim = lim_sel ? int'(lim_loose) : int'(lim_tight);
          if (meas == 0 || d > lim) begin
            m_alarm[i] = 1; m_pass[i] = 0;
          end else if (m_alarm[i] && m_pass[i]) begin
            m_alarm[i] = 0; m_pass[i] = 0;
          end else begin
            m_pass[i] = m_alarm[i];
          end
          cnt[i] = 0;
        end else begin
          cnt[i] = cnt[i] + int'(inc);
        end
      end
      wpos = lst ? 0 : wpos + 1;
      m_win = lst;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [NMON-1:0] ea;
      for (int i = 0; i < NMON; i++) ea[i] = m_alarm[i];
      n_cmp++;
      if (alarm !== ea || win_end !== m_win) begin
        n_bad++;
        $display("FAIL R4 model compare t=%0t alarm=%b exp=%b win_end=%b exp=%b",
                 $time, alarm, ea, win_end, m_win);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_end();
    do @(negedge clk); while (!win_end);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ex[0] = CW'(16); ex[1] = CW'(16); ex[2] = CW'(8);
    repeat (3) @(negedge clk);
    check("R1 alarm in reset", int'(alarm), 0);
    check("R1 win_end in reset", int'(win_end), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 alarm after release", int'(alarm), 0);
    check("R1 win_end after release", int'(win_end), 0);

    repeat (4) wait_end();
    check("R3 all within limit", int'(alarm), 0);

    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!win_end);
      check("R2 window period", n, 64);
    end

    ex[1] = CW'(18);
    wait_end();
    check("R4 R8 offset 2 over tight limit", int'(alarm), 3'b010);

    lim_sel = 1'b1;
    wait_end();
    check("R7 one passing window holds", int'(alarm), 3'b010);
    wait_end();
    check("R5 R7 loose limit clears after two", int'(alarm), 3'b000);

    ex[1] = CW'(20);
    wait_end();
    check("R4 difference equal to limit passes", int'(alarm), 3'b000);
    ex[1] = CW'(21);
    wait_end();
    check("R4 difference above limit fails", int'(alarm), 3'b010);
    ex[1] = CW'(16);
    wait_end();
    wait_end();
    check("R7 cleared after restore", int'(alarm), 3'b000);

    hp[2] = 0; ex[2] = CW'(0);
    repeat (3) wait_end();
    check("R6 R8 stopped input alarms alone", int'(alarm), 3'b100);

    @(negedge clk); #1 rst_n = 1'b0; gate_len = '0;
    repeat (3) @(negedge clk);
    check("R1 alarm after second reset", int'(alarm), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R2 zero gate gives window every cycle", int'(win_end), 1);
    end
    repeat (20) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule